// File: doc/BRIEF.md
# Store-Merging Load/Store Unit with Pipelined Bus Master

This unit sits between a processor's issue stage and a Wishbone pipelined bus. It takes one load or store per clock from issue and puts each one on the bus as a strobe. While a bus cycle is open, it keeps it open for a new operation only if the new word address equals the previous request's word address or the word right after it. Since every request in a cycle then goes to the same slave, acknowledgements come back in order. An operation that fails that test is held off, with `busy` high, until the open cycle has drained and `wb_cyc` has dropped. It then starts a new cycle.

A small in-order tag queue records the kind, destination register, access size and byte offset of each request. When an acknowledgement arrives, the queue head tells the unit whether a load has finished. If so, the read lane is shifted down and zero-extended and returned with its register index. Stores write no register. Issue logic therefore only needs to hold register-writing instructions while `reg_hazard` is high, and stores never raise it. A bus error closes the cycle at once, flushes the tag queue and pulses `bus_fault`.

The control is a three-state machine. `ST_IDLE` has no cycle open. `ST_ISSUE` has the strobe raised. `ST_WAIT` has the cycle open and the strobe low while acknowledgements are pending. Its transitions are:
- idle→issue on an accepted operation.
- issue→issue while stalled or when another operation merges.
- issue→wait when the strobe is taken and nothing follows.
- wait→issue on a merging operation.
- wait/issue→idle when the count of outstanding acknowledgements reaches zero, or on a bus error.

Top module: `stmerge_lsu`

## Requirements
- R1: After reset, `wb_cyc`, `wb_stb`, `ld_valid`, `bus_fault`, `reg_hazard` and `busy` are all low.
- R2: Byte enables and write lanes come from `op_size` and `op_addr[1:0]`:
  - size 0 (byte): `wb_sel` = 1 shifted left by `op_addr[1:0]`, and the low byte is copied to all four lanes.
  - size 1 (half): `wb_sel` = 4'b0011, or 4'b1100 when `op_addr[1]` is set, and the low half is copied to both halves.
  - size 2 (word): `wb_sel` = 4'b1111 and the data is passed through.
  - `wb_adr` is `op_addr[AW-1:2]`.
- R3: While a cycle is open, an operation whose word address equals the last issued word address, or that address plus one, is accepted without waiting. Its strobe follows on the next clock in the same cycle, so back-to-back strobes are possible.
- R4: While a cycle is open, any other address keeps `busy` high until every acknowledgement has returned and `wb_cyc` has fallen. The operation is then issued in a fresh cycle.
- R5: While `wb_stall` is high with the strobe raised, `wb_stb`, `wb_adr`, `wb_sel` and `wb_we` hold their values and a new operation sees `busy` high.
- R6: The outstanding acknowledgements plus a raised strobe never exceed MAX_OUT. An operation that would exceed the limit sees `busy` high until an acknowledgement frees a slot.
- R7: One clock after the acknowledgement of a load, `ld_valid` pulses with that load's `ld_reg`. `ld_data` holds the addressed byte or half-word shifted to bit 0 and zero-extended. Results come back in request order.
- R8: `reg_hazard` is high exactly while at least one load is unacknowledged. Stores never raise it.
- R9: `wb_err` during an open cycle drops `wb_cyc` on the next clock and pulses `bus_fault` for one clock. Pending loads are discarded and produce no `ld_valid`.
- R10: With no new operation, `wb_cyc` falls on the clock after the last outstanding acknowledgement.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| op_valid | input | 1 | Issue presents an operation |
| op_load | input | 1 | 1 = load, 0 = store |
| op_size | input | 2 | 0 byte, 1 half-word, 2 word |
| op_addr | input | AW | Byte address |
| op_wdata | input | 32 | Store data, right-aligned |
| op_reg | input | RW | Destination register of a load |
| busy | output | 1 | Presented operation not accepted this clock |
| reg_hazard | output | 1 | A load is still outstanding |
| ld_valid | output | 1 | Load result valid |
| ld_reg | output | RW | Register index of the result |
| ld_data | output | 32 | Aligned, zero-extended load data |
| bus_fault | output | 1 | One-clock pulse after a bus error |
| wb_cyc | output | 1 | Bus cycle |
| wb_stb | output | 1 | Request strobe |
| wb_we | output | 1 | Write enable |
| wb_adr | output | AW-2 | Word address |
| wb_dato | output | 32 | Write data |
| wb_sel | output | 4 | Byte enables |
| wb_stall | input | 1 | Slave cannot take the strobe |
| wb_ack | input | 1 | Request acknowledged |
| wb_err | input | 1 | Request failed |
| wb_dati | input | 32 | Read data |

## Verification
The bound checker watches the bus side on every clock:
- Every new strobe in a cycle stays on the same or the next word.
- A stalled request is held unchanged.
- The outstanding count stays within its limit.
- The cycle falls only when that count is empty or after an error.
- A load result is always preceded by an acknowledgement.
- `reg_hazard` is never raised outside a cycle.

Only the bench's scenarios show the parts that depend on the data values:
- The exact lane and byte-enable patterns.
- Which address candidates are refused.
- The order and alignment of returned load data.
- That a flushed load yields no result.

// File: rtl/stmerge_pkg.sv
package stmerge_pkg;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_ISSUE = 2'd1,
        ST_WAIT  = 2'd2
    } lsu_state_t;

    typedef enum logic [1:0] {
        SZ_BYTE = 2'd0,
        SZ_HALF = 2'd1,
        SZ_WORD = 2'd2
    } acc_size_t;

    localparam int LANES = 4;

endpackage

// File: rtl/stmerge_lanes.sv
module stmerge_lanes
    import stmerge_pkg::*;
(
    input  logic [1:0]       size,
    input  logic [1:0]       off,
    input  logic [31:0]      wdata,
    output logic [LANES-1:0] sel,
    output logic [31:0]      lane_data
);
    always_comb begin
        unique case (size)
            SZ_BYTE: begin
                sel       = 4'b0001 << off;
                lane_data = {4{wdata[7:0]}};
            end
            SZ_HALF: begin
                sel       = off[1] ? 4'b1100 : 4'b0011;
                lane_data = {2{wdata[15:0]}};
            end
            default: begin
                sel       = 4'b1111;
                lane_data = wdata;
            end
        endcase
    end
endmodule

// File: rtl/stmerge_align.sv
module stmerge_align
    import stmerge_pkg::*;
(
    input  logic [1:0]  size,
    input  logic [1:0]  off,
    input  logic [31:0] rdata,
    output logic [31:0] value
);
    logic [31:0] shifted;

    always_comb begin
        shifted = rdata;
        value   = rdata;
        unique case (size)
            SZ_BYTE: begin
                shifted = rdata >> {off, 3'b000};
                value   = {24'd0, shifted[7:0]};
            end
            SZ_HALF: begin
                shifted = rdata >> {off[1], 4'b0000};
                value   = {16'd0, shifted[15:0]};
            end
            default: begin
                shifted = rdata;
                value   = rdata;
            end
        endcase
    end
endmodule

// File: rtl/stmerge_tagq.sv
module stmerge_tagq #(
    parameter int DEPTH = 4,
    parameter int W     = 10
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         flush,
    input  logic         push,
    input  logic [W-1:0] push_data,
    input  logic         pop,
    output logic [W-1:0] head
);
    localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

    logic [W-1:0]  slots [DEPTH];
    logic [PW-1:0] wr_ptr, rd_ptr;

    function automatic logic [PW-1:0] bump(input logic [PW-1:0] p);
        return (p == PW'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    generate
        for (genvar i = 0; i < DEPTH; i++) begin : g_slot
            always_ff @(posedge clk) begin
                if (push && wr_ptr == PW'(i))
                    slots[i] <= push_data;
            end
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (!rst_n || flush) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
        end else begin
            if (push) wr_ptr <= bump(wr_ptr);
            if (pop)  rd_ptr <= bump(rd_ptr);
        end
    end

    assign head = slots[rd_ptr];
endmodule

// File: rtl/stmerge_lsu.sv
module stmerge_lsu
    import stmerge_pkg::*;
#(
    parameter int AW      = 32,
    parameter int RW      = 5,
    parameter int MAX_OUT = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          op_valid,
    input  logic          op_load,
    input  logic [1:0]    op_size,
    input  logic [AW-1:0] op_addr,
    input  logic [31:0]   op_wdata,
    input  logic [RW-1:0] op_reg,
    output logic          busy,
    output logic          reg_hazard,
    output logic          ld_valid,
    output logic [RW-1:0] ld_reg,
    output logic [31:0]   ld_data,
    output logic          bus_fault,
    output logic          wb_cyc,
    output logic          wb_stb,
    output logic          wb_we,
    output logic [AW-3:0] wb_adr,
    output logic [31:0]   wb_dato,
    output logic [3:0]    wb_sel,
    input  logic          wb_stall,
    input  logic          wb_ack,
    input  logic          wb_err,
    input  logic [31:0]   wb_dati
);
    localparam int CW = $clog2(MAX_OUT + 1);
    localparam int QW = 1 + RW + 4;

    lsu_state_t    state, state_n;
    logic [CW-1:0] out_cnt, out_cnt_n, ld_cnt;
    logic [CW:0]   inflight;
    logic [AW-3:0] op_wadr, last_wadr;
    logic          is_open, is_issue, str_taken, ack_hit, err_hit;
    logic          merge_ok, full, take;
    logic [3:0]    new_sel;
    logic [31:0]   new_data, aligned;
    logic [QW-1:0] q_head;
    logic          h_load;
    logic [RW-1:0] h_reg;
    logic [1:0]    h_size, h_off;

    assign op_wadr   = op_addr[AW-1:2];
    assign is_open   = (state != ST_IDLE);
    assign is_issue  = (state == ST_ISSUE);
    assign str_taken = is_issue && !wb_stall;
    assign ack_hit   = is_open && wb_ack && (out_cnt != '0);
    assign err_hit   = is_open && wb_err;
    assign merge_ok  = (op_wadr == last_wadr) || (op_wadr == last_wadr + 1'b1);
    assign inflight  = {1'b0, out_cnt} + {{CW{1'b0}}, is_issue};
    assign full      = inflight >= (CW+1)'(MAX_OUT);

    always_comb begin
        take = 1'b0;
        if (op_valid && !err_hit && !full) begin
            if (state == ST_IDLE)
                take = 1'b1;
            else
                take = merge_ok && !(is_issue && wb_stall);
        end
    end

    assign busy      = op_valid && !take;
    assign out_cnt_n = err_hit ? '0 : out_cnt + CW'(str_taken) - CW'(ack_hit);

    // next-state logic
    always_comb begin
        state_n = state;
        unique case (state)
            ST_IDLE:  if (take) state_n = ST_ISSUE;
            ST_ISSUE: begin
                if (err_hit)                   state_n = ST_IDLE;
                else if (wb_stall || take)     state_n = ST_ISSUE;
                else if (out_cnt_n == '0)      state_n = ST_IDLE;
                else                           state_n = ST_WAIT;
            end
            ST_WAIT: begin
                if (err_hit)                   state_n = ST_IDLE;
                else if (take)                 state_n = ST_ISSUE;
                else if (out_cnt_n == '0)      state_n = ST_IDLE;
                else                           state_n = ST_WAIT;
            end
            default:                           state_n = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_n;
    end

    // bus outputs follow the state
    always_comb begin
        wb_cyc = is_open;
        wb_stb = is_issue;
    end

    stmerge_lanes u_lanes (
        .size      (op_size),
        .off       (op_addr[1:0]),
        .wdata     (op_wdata),
        .sel       (new_sel),
        .lane_data (new_data)
    );

    stmerge_tagq #(.DEPTH(MAX_OUT), .W(QW)) u_tagq (
        .clk       (clk),
        .rst_n     (rst_n),
        .flush     (err_hit),
        .push      (take),
        .push_data ({op_load, op_reg, op_size, op_addr[1:0]}),
        .pop       (ack_hit),
        .head      (q_head)
    );

    assign {h_load, h_reg, h_size, h_off} = q_head;

    stmerge_align u_align (
        .size  (h_size),
        .off   (h_off),
        .rdata (wb_dati),
        .value (aligned)
    );

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_cnt   <= '0;
            ld_cnt    <= '0;
            last_wadr <= '0;
            wb_adr    <= '0;
            wb_we     <= 1'b0;
            wb_dato   <= '0;
            wb_sel    <= '0;
            ld_valid  <= 1'b0;
            ld_reg    <= '0;
            ld_data   <= '0;
            bus_fault <= 1'b0;
        end else begin
            out_cnt   <= out_cnt_n;
            bus_fault <= err_hit;
            ld_valid  <= 1'b0;
            if (take) begin
                last_wadr <= op_wadr;
                wb_adr    <= op_wadr;
                wb_we     <= !op_load;
                wb_dato   <= new_data;
                wb_sel    <= new_sel;
            end
            if (err_hit)
                ld_cnt <= '0;
            else
                ld_cnt <= ld_cnt + CW'(take && op_load) - CW'(ack_hit && h_load);
            if (ack_hit && h_load && !err_hit) begin
                ld_valid <= 1'b1;
                ld_reg   <= h_reg;
                ld_data  <= aligned;
            end
        end
    end

    assign reg_hazard = (ld_cnt != '0);
endmodule

// File: rtl/stmerge_lsu_chk.sv
module stmerge_lsu_chk #(
    parameter int AW      = 32,
    parameter int MAX_OUT = 4
) (
    input logic          clk,
    input logic          rst_n,
    input logic          wb_cyc,
    input logic          wb_stb,
    input logic          wb_we,
    input logic [AW-3:0] wb_adr,
    input logic [3:0]    wb_sel,
    input logic          wb_stall,
    input logic          wb_ack,
    input logic          wb_err,
    input logic          bus_fault,
    input logic          reg_hazard,
    input logic          ld_valid
);
    localparam int CW = $clog2(MAX_OUT + 1);

    logic [AW-3:0] prev_adr;
    logic          have_prev;
    logic [CW:0]   oc;

    always_ff @(posedge clk) begin
        if (!rst_n || !wb_cyc || wb_err) begin
            have_prev <= 1'b0;
            oc        <= '0;
            prev_adr  <= '0;
        end else begin
            if (wb_stb && !wb_stall) begin
                prev_adr  <= wb_adr;
                have_prev <= 1'b1;
            end
            oc <= oc + (CW+1)'(wb_stb && !wb_stall) - (CW+1)'(wb_ack && oc != '0);
        end
    end

    a_r2_sel_nonzero: assert property (@(posedge clk) disable iff (!rst_n)
        wb_stb |-> wb_sel != 4'b0000);

    a_r3_stb_in_cyc: assert property (@(posedge clk) disable iff (!rst_n)
        wb_stb |-> wb_cyc);

    a_r3_seq_addr: assert property (@(posedge clk) disable iff (!rst_n)
        wb_cyc && wb_stb && have_prev |-> (wb_adr == prev_adr) || (wb_adr == prev_adr + 1'b1));

    a_r5_hold_stalled: assert property (@(posedge clk) disable iff (!rst_n)
        wb_stb && wb_stall && !wb_err |=> wb_stb && $stable(wb_adr) && $stable(wb_sel) && $stable(wb_we));

    a_r6_limit: assert property (@(posedge clk) disable iff (!rst_n)
        wb_cyc |-> (oc + (CW+1)'(wb_stb)) <= (CW+1)'(MAX_OUT));

    a_r7_result_after_ack: assert property (@(posedge clk) disable iff (!rst_n)
        ld_valid |-> $past(wb_cyc && wb_ack));

    a_r8_no_hazard_idle: assert property (@(posedge clk) disable iff (!rst_n)
        !wb_cyc |-> !reg_hazard);

    a_r9_err_closes: assert property (@(posedge clk) disable iff (!rst_n)
        wb_cyc && wb_err |=> !wb_cyc && bus_fault);

    a_r10_drop_empty: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(wb_cyc) && !$past(wb_err) |-> oc == '0);
endmodule

bind stmerge_lsu stmerge_lsu_chk #(.AW(AW), .MAX_OUT(MAX_OUT)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .wb_cyc     (wb_cyc),
    .wb_stb     (wb_stb),
    .wb_we      (wb_we),
    .wb_adr     (wb_adr),
    .wb_sel     (wb_sel),
    .wb_stall   (wb_stall),
    .wb_ack     (wb_ack),
    .wb_err     (wb_err),
    .bus_fault  (bus_fault),
    .reg_hazard (reg_hazard),
    .ld_valid   (ld_valid)
);

// File: tb/sim_stmerge_lsu.sv
`timescale 1ns/1ps
module sim_stmerge_lsu;
    localparam int AW = 32;
    localparam int RW = 5;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          op_valid = 1'b0, op_load = 1'b0;
    logic [1:0]    op_size = 2'd2;
    logic [AW-1:0] op_addr = '0;
    logic [31:0]   op_wdata = '0;
    logic [RW-1:0] op_reg = '0;
    logic          busy, reg_hazard, ld_valid, bus_fault;
    logic [RW-1:0] ld_reg;
    logic [31:0]   ld_data;
    logic          wb_cyc, wb_stb, wb_we;
    logic [AW-3:0] wb_adr;
    logic [31:0]   wb_dato;
    logic [3:0]    wb_sel;
    logic          wb_stall = 1'b0, wb_ack = 1'b0, wb_err = 1'b0;
    logic [31:0]   wb_dati = '0;

    int n_chk = 0;
    int n_bad = 0;

    always #10 clk = ~clk;

    stmerge_lsu #(.AW(AW), .RW(RW), .MAX_OUT(4)) u0 (
        .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_load(op_load),
        .op_size(op_size), .op_addr(op_addr), .op_wdata(op_wdata), .op_reg(op_reg),
        .busy(busy), .reg_hazard(reg_hazard), .ld_valid(ld_valid), .ld_reg(ld_reg),
        .ld_data(ld_data), .bus_fault(bus_fault), .wb_cyc(wb_cyc), .wb_stb(wb_stb),
        .wb_we(wb_we), .wb_adr(wb_adr), .wb_dato(wb_dato), .wb_sel(wb_sel),
        .wb_stall(wb_stall), .wb_ack(wb_ack), .wb_err(wb_err), .wb_dati(wb_dati)
    );

    // size, offset, write data, expected sel, expected lane data
    localparam logic [71:0] VEC [7] = '{
        {2'd0, 2'd0, 32'h0000_00A5, 4'b0001, 32'hA5A5_A5A5},
        {2'd0, 2'd3, 32'h0000_003C, 4'b1000, 32'h3C3C_3C3C},
        {2'd0, 2'd1, 32'h1234_5677, 4'b0010, 32'h7777_7777},
        {2'd1, 2'd0, 32'h0000_BEEF, 4'b0011, 32'hBEEF_BEEF},
        {2'd1, 2'd2, 32'hFFFF_1234, 4'b1100, 32'h1234_1234},
        {2'd2, 2'd0, 32'hCAFE_F00D, 4'b1111, 32'hCAFE_F00D},
        {2'd0, 2'd2, 32'h0000_0001, 4'b0100, 32'h0101_0101}
    };

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic present(input logic ld, input logic [1:0] sz, input logic [31:0] a,
                           input logic [31:0] d, input logic [RW-1:0] r);
        op_valid = 1'b1; op_load = ld; op_size = sz; op_addr = a; op_wdata = d; op_reg = r;
        #1;
    endtask

    task automatic idle_op();
        op_valid = 1'b0;
        #1;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog expired");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R1 reset state
        chk("R1 cyc", 32'(wb_cyc), 0);
        chk("R1 stb", 32'(wb_stb), 0);
        chk("R1 ld_valid", 32'(ld_valid), 0);
        chk("R1 bus_fault", 32'(bus_fault), 0);
        chk("R1 reg_hazard", 32'(reg_hazard), 0);
        chk("R1 busy", 32'(busy), 0);
        rst_n = 1'b1;
        tick();

        // R2 lanes and byte enables, walked from the table
        for (int i = 0; i < 7; i++) begin
            logic [31:0] a;
            a = 32'h800 + 32'(i * 16) + 32'(VEC[i][69:68]);
            present(1'b0, VEC[i][71:70], a, VEC[i][67:36], '0);
            chk("R2 accept", 32'(busy), 0);
            tick();
            idle_op();
            chk("R2 stb", 32'(wb_stb), 1);
            chk("R2 we", 32'(wb_we), 1);
            chk("R2 sel", 32'(wb_sel), 32'(VEC[i][35:32]));
            chk("R2 data", wb_dato, VEC[i][31:0]);
            chk("R2 adr", 32'(wb_adr), a >> 2);
            tick();
            chk("R8 store no hazard", 32'(reg_hazard), 0);
            wb_ack = 1'b1;
            tick();
            wb_ack = 1'b0;
            chk("R10 cyc drops", 32'(wb_cyc), 0);
        end

        // R3 merge: same and next word join one cycle
        present(1'b0, 2'd2, 32'h100, 32'h1, '0);
        tick();
        present(1'b0, 2'd2, 32'h104, 32'h2, '0);
        chk("R3 next word busy", 32'(busy), 0);
        tick();
        chk("R3 back-to-back adr", 32'(wb_adr), 32'h41);
        chk("R3 strobe kept", 32'(wb_stb), 1);
        present(1'b0, 2'd2, 32'h104, 32'h3, '0);
        chk("R3 same word busy", 32'(busy), 0);
        tick();
        idle_op();
        chk("R3 third adr", 32'(wb_dato), 32'h3);
        tick();
        chk("R3 wait cyc", 32'(wb_cyc), 1);
        chk("R3 wait stb", 32'(wb_stb), 0);
        wb_ack = 1'b1;
        tick(); tick();
        chk("R10 cyc held with ack pending", 32'(wb_cyc), 1);
        tick();
        wb_ack = 1'b0;
        chk("R10 cyc drops after last", 32'(wb_cyc), 0);

        // R4 non-mergeable address waits for drain
        present(1'b0, 2'd2, 32'h200, 32'h5, '0);
        tick();
        present(1'b0, 2'd2, 32'h300, 32'h6, '0);
        chk("R4 far addr busy", 32'(busy), 1);
        tick();
        present(1'b0, 2'd2, 32'h1FC, 32'h6, '0);
        chk("R4 prev word busy", 32'(busy), 1);
        present(1'b0, 2'd2, 32'h208, 32'h6, '0);
        chk("R4 skip word busy", 32'(busy), 1);
        present(1'b0, 2'd2, 32'h300, 32'h6, '0);
        wb_ack = 1'b1;
        #1;
        chk("R4 busy during last ack", 32'(busy), 1);
        tick();
        wb_ack = 1'b0;
        #1;
        chk("R4 cyc dropped", 32'(wb_cyc), 0);
        chk("R4 accepted when idle", 32'(busy), 0);
        tick();
        idle_op();
        chk("R4 new cycle adr", 32'(wb_adr), 32'hC0);
        chk("R4 new cycle cyc", 32'(wb_cyc), 1);
        tick();
        wb_ack = 1'b1;
        tick();
        wb_ack = 1'b0;

        // R5 stall holds request
        present(1'b0, 2'd2, 32'h400, 32'h7, '0);
        tick();
        wb_stall = 1'b1;
        present(1'b0, 2'd2, 32'h404, 32'h8, '0);
        chk("R5 busy while stalled", 32'(busy), 1);
        tick();
        chk("R5 stb held", 32'(wb_stb), 1);
        chk("R5 adr held", 32'(wb_adr), 32'h100);
        wb_stall = 1'b0;
        #1;
        chk("R5 accept after stall", 32'(busy), 0);
        tick();
        idle_op();
        chk("R5 second adr", 32'(wb_adr), 32'h101);
        tick();
        wb_ack = 1'b1;
        tick(); tick();
        wb_ack = 1'b0;
        chk("R5 done", 32'(wb_cyc), 0);

        // R6 outstanding limit of four
        for (int k = 0; k < 4; k++) begin
            present(1'b0, 2'd2, 32'h500 + 32'(k * 4), 32'(k), '0);
            chk("R6 under limit", 32'(busy), 0);
            tick();
        end
        present(1'b0, 2'd2, 32'h510, 32'h9, '0);
        chk("R6 busy at limit issue", 32'(busy), 1);
        tick();
        chk("R6 busy at limit wait", 32'(busy), 1);
        wb_ack = 1'b1;
        #1;
        chk("R6 busy until ack counted", 32'(busy), 1);
        tick();
        wb_ack = 1'b0;
        #1;
        chk("R6 slot freed", 32'(busy), 0);
        tick();
        idle_op();
        chk("R6 fifth adr", 32'(wb_adr), 32'h144);
        tick();
        wb_ack = 1'b1;
        tick(); tick(); tick(); tick();
        wb_ack = 1'b0;
        chk("R6 drained", 32'(wb_cyc), 0);

        // R7 R8 loads in order, mixed with a store
        present(1'b1, 2'd0, 32'h602, '0, 5'd3);
        tick();
        chk("R8 hazard with load", 32'(reg_hazard), 1);
        present(1'b1, 2'd1, 32'h606, '0, 5'd7);
        tick();
        present(1'b0, 2'd2, 32'h604, 32'hABCD, '0);
        tick();
        idle_op();
        tick();
        wb_ack = 1'b1; wb_dati = 32'hAABB_CCDD;
        tick();
        chk("R7 first valid", 32'(ld_valid), 1);
        chk("R7 first reg", 32'(ld_reg), 3);
        chk("R7 byte data", ld_data, 32'h0000_00BB);
        chk("R8 hazard second load", 32'(reg_hazard), 1);
        wb_dati = 32'h1122_3344;
        tick();
        chk("R7 second reg", 32'(ld_reg), 7);
        chk("R7 half data", ld_data, 32'h0000_1122);
        chk("R8 hazard cleared", 32'(reg_hazard), 0);
        wb_dati = 32'h0;
        tick();
        wb_ack = 1'b0;
        chk("R7 store gives no result", 32'(ld_valid), 0);
        chk("R7 cycle done", 32'(wb_cyc), 0);

        // R9 bus error flushes loads
        present(1'b1, 2'd2, 32'h700, '0, 5'd4);
        tick();
        present(1'b1, 2'd2, 32'h704, '0, 5'd5);
        tick();
        idle_op();
        tick();
        wb_err = 1'b1;
        tick();
        wb_err = 1'b0;
        chk("R9 cyc dropped", 32'(wb_cyc), 0);
        chk("R9 fault pulse", 32'(bus_fault), 1);
        chk("R9 no result", 32'(ld_valid), 0);
        chk("R9 hazard cleared", 32'(reg_hazard), 0);
        wb_ack = 1'b1; wb_dati = 32'hDEAD_BEEF;
        tick();
        wb_ack = 1'b0;
        chk("R9 stray ack ignored", 32'(ld_valid), 0);
        chk("R9 fault one clock", 32'(bus_fault), 0);
        chk("R9 still idle", 32'(wb_cyc), 0);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule